// File: doc/BRIEF.md
# Dual-Mode Serial Unit (UART / SPI Master)

This block is a serial port with two operating modes behind one small register set. In asynchronous mode it is a full-duplex UART carrying 8N1 characters (one start bit, eight data bits sent least significant bit first, one stop bit). The receiver uses 16x oversampling and samples each bit near its middle. In synchronous mode it is an SPI master. It drives its own serial clock, sends the most significant bit first and handles words of 1 to 16 bits.

Both modes use the same transmit holding register and the same receive holding register. Each holding register sits in front of a shift engine, so software can queue one word while another is on the wire. The bit clock comes from one of two sources, chosen by a control bit: an internal programmable divider, or the rising edges of an external timer tick input. Five event flags drive a flag output and can be read in a status register. They report receive holding full, transmit holding empty, overrun, framing error and SPI transfer completion.

Registers are accessed through a write strobe and a read strobe with a 2-bit address. Read data is registered and appears the cycle after the read strobe.

Register map (addr):
- 0 control: bit 0 selects SPI mode (1) or UART mode (0), bit 1 selects the external tick source (1) or the internal divider (0), bits 7:4 hold the SPI word length minus one.
- 1 data: a write fills the transmit holding register, and a read returns the receive holding register.
- 2 status: flag bits. Writing 1 to bits 2, 3 or 4 clears that bit.
- 3 divider.

Top module: `serial_duo`

## Requirements
- R1: After reset, txd is 1, sclk is 0 and the flags read 5'b00010. The flag bits are: bit0 receive full, bit1 transmit holding empty, bit2 overrun, bit3 framing error, bit4 SPI done.
- R2: With the internal source selected, one tick occurs every divider+1 clocks. In UART mode every bit lasts 16 ticks, and a frame is a 0 start bit, the eight data bits LSB first, then a 1 stop bit.
- R3: A data write that lands while the transmit holding register is empty is accepted. The word moves to the shifter as soon as the shifter is idle, which sets transmit-empty again, so a second word can wait while the first is sent. A data write while the holding register is full is ignored.
- R4: A received character with a valid stop bit lands in the receive holding register and sets receive full. Reading address 1 returns the character and clears receive full.
- R5: If a character completes while receive full is set, the overrun flag is set, the new character is discarded and the held character is kept.
- R6: If the stop bit samples 0, the framing error flag is set and the character is discarded, so receive full is unchanged. The receiver waits for the line to return high before it accepts another start bit.
- R7: In SPI mode the word length is control bits 7:4 plus 1 (1 to 16). MOSI sends the lowest `length` bits of the written word MSB first. MOSI changes only on falling SCLK edges, MISO is sampled on rising edges, and SCLK idles low. Received data is right-aligned and zero-filled above the length.
- R8: At the end of an SPI word the SPI done flag is set and the received word goes to the receive holding register, following the same full/overrun rule as in R5.
- R9: With the external source selected, each rising edge of ext_tick produces exactly one tick, and with no edges the serial clock does not move. In SPI mode one tick is one SCLK half period, so an N-bit word needs 2N edges.
- R10: Writing 1 to status bits 2, 3 or 4 clears the matching sticky flag, and writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data, valid the cycle after rd_en |
| flags | output | 5 | Event flags: rx full, tx empty, overrun, framing, SPI done |
| ext_tick | input | 1 | External timer tick; each rising edge is one tick |
| rxd | input | 1 | UART receive line |
| txd | output | 1 | UART transmit line |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |

## Verification
The hardest states to reach from the ports are the receive-side error paths, because they need characters with exact timing. The bench serialises frames at the programmed bit period. It leaves the first character unread to force an overrun, and it drives a low stop bit to force a framing error. The frame after the framing error checks that the receiver does not invent a character from the low tail of that stop bit. The external tick path is checked by counting edges one by one: completion must not appear after 2N-1 edges and must appear after 2N.

// File: rtl/serial_duo_pkg.sv
package serial_duo_pkg;
  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_DATA = 2'd1,
    A_STAT = 2'd2,
    A_DIV  = 2'd3
  } reg_addr_e;

  localparam int FLAG_N   = 5;
  localparam int F_RXFULL = 0;
  localparam int F_TXEMPT = 1;
  localparam int F_OVR    = 2;
  localparam int F_FRAME  = 3;
  localparam int F_SDONE  = 4;
endpackage

// File: rtl/sd_tick_gen.sv
module sd_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_ext,
  input  logic [DIV_W-1:0] div,
  input  logic             ext_in,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             s1, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
      s1   <= 1'b0;
      s2   <= 1'b0;
    end else begin
      s1 <= ext_in;
      s2 <= s1;
      if (sel_ext) begin
        cnt  <= '0;
        tick <= s1 & ~s2;
      end else if (cnt >= div) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt  <= cnt + 1'b1;
        tick <= 1'b0;
      end
    end
  end

  // R9: external source gives one tick per rising edge, never two in a row
  a_r9_single_tick: assert property (@(posedge clk) disable iff (rst)
    (sel_ext && $past(sel_ext) && tick) |=> !tick);
endmodule

// File: rtl/sd_uart_tx.sv
module sd_uart_tx #(
  parameter int CHAR_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              start,
  input  logic [CHAR_W-1:0] data,
  output logic              busy,
  output logic              txd
);
  localparam int SW = $clog2(OVS);
  localparam int BW = $clog2(CHAR_W + 2);

  logic [CHAR_W:0] sh;
  logic [SW-1:0]   sub;
  logic [BW-1:0]   bitn;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      txd  <= 1'b1;
      sh   <= '1;
      sub  <= '0;
      bitn <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      txd  <= 1'b0;
      sh   <= {1'b1, data};
      sub  <= '0;
      bitn <= '0;
    end else if (busy && tick) begin
      if (sub == SW'(OVS - 1)) begin
        sub <= '0;
        if (bitn == BW'(CHAR_W + 1)) begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end else begin
          txd  <= sh[0];
          sh   <= {1'b1, sh[CHAR_W:1]};
          bitn <= bitn + 1'b1;
        end
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  // R2: line is high whenever no frame is in flight
  a_r2_idle_high: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
endmodule

// File: rtl/sd_uart_rx.sv
module sd_uart_rx #(
  parameter int CHAR_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic              rxd,
  output logic              done,
  output logic              ferr,
  output logic [CHAR_W-1:0] data
);
  localparam int SW = $clog2(OVS);
  localparam int BW = $clog2(CHAR_W + 2);

  logic          r1, r2, busy, armed;
  logic [SW-1:0] sub;
  logic [BW-1:0] bitn;

  always_ff @(posedge clk) begin
    if (rst) begin
      r1 <= 1'b1; r2 <= 1'b1;
      busy <= 1'b0; armed <= 1'b0;
      sub <= '0; bitn <= '0;
      done <= 1'b0; ferr <= 1'b0;
      data <= '0;
    end else begin
      r1   <= rxd;
      r2   <= r1;
      done <= 1'b0;
      ferr <= 1'b0;
      if (!en) begin
        busy  <= 1'b0;
        armed <= 1'b0;
      end else if (!busy) begin
        if (r2) armed <= 1'b1;
        else if (tick && armed) begin
          busy  <= 1'b1;
          armed <= 1'b0;
          sub   <= '0;
          bitn  <= '0;
        end
      end else if (tick) begin
        if (bitn == '0) begin
          if (sub == SW'(OVS / 2 - 1)) begin
            sub <= '0;
            if (r2) busy <= 1'b0;
            else    bitn <= 1'b1;
          end else sub <= sub + 1'b1;
        end else if (sub == SW'(OVS - 1)) begin
          sub <= '0;
          if (bitn <= BW'(CHAR_W)) begin
            data <= {r2, data[CHAR_W-1:1]};
            bitn <= bitn + 1'b1;
          end else begin
            busy <= 1'b0;
            if (r2) done <= 1'b1;
            else    ferr <= 1'b1;
          end
        end else sub <= sub + 1'b1;
      end
    end
  end

  // R6: a completed character is either good or bad, never both
  a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done && ferr));
endmodule

// File: rtl/sd_spi_master.sv
module sd_spi_master #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  input  logic [LEN_W-1:0]  lenm1,
  input  logic              miso,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic              done,
  output logic [DATA_W-1:0] rword
);
  logic [DATA_W-1:0] sh, nxt, masked;
  logic [LEN_W-1:0]  cnt, len_q;
  logic              samp;

  assign nxt = {sh[DATA_W-2:0], samp};

  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      masked[i] = (LEN_W'(i) <= len_q) ? nxt[i] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; sclk <= 1'b0; mosi <= 1'b0; done <= 1'b0;
      sh <= '0; cnt <= '0; len_q <= '0; samp <= 1'b0; rword <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy  <= 1'b1;
        sclk  <= 1'b0;
        sh    <= data;
        len_q <= lenm1;
        cnt   <= '0;
        mosi  <= data[lenm1];
      end else if (busy && tick) begin
        if (!sclk) begin
          sclk <= 1'b1;
          samp <= miso;
        end else begin
          sclk <= 1'b0;
          sh   <= nxt;
          if (cnt == len_q) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            rword <= masked;
          end else begin
            cnt  <= cnt + 1'b1;
            mosi <= nxt[len_q];
          end
        end
      end
    end
  end

  // R7: serial clock rests low between words
  a_r7_sclk_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk);
  // R7: during a word MOSI only moves together with a falling SCLK
  a_r7_mosi_on_fall: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$stable(mosi)) |-> $fell(sclk));
endmodule

// File: rtl/serial_duo.sv
module serial_duo
  import serial_duo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8,
  parameter int DIV_W  = 16,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [FLAG_N-1:0] flags,
  input  logic              ext_tick,
  input  logic              rxd,
  output logic              txd,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  localparam int LEN_W = $clog2(DATA_W);

  logic              mode_spi, clk_ext;
  logic [LEN_W-1:0]  lenm1;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] tx_hold, rx_hold, spi_word;
  logic              tx_full, rx_full, ovr, frm, sdone;
  logic              tick, utx_busy, spi_busy, urx_done, urx_ferr, spi_done;
  logic [CHAR_W-1:0] urx_data;
  logic              uart_start, spi_start, rx_new;
  logic [DATA_W-1:0] rx_val;
  logic              wr_data, wr_stat, rd_data;

  assign wr_data    = wr_en && (addr == A_DATA);
  assign wr_stat    = wr_en && (addr == A_STAT);
  assign rd_data    = rd_en && (addr == A_DATA);
  assign uart_start = !mode_spi && tx_full && !utx_busy;
  assign spi_start  = mode_spi && tx_full && !spi_busy;
  assign rx_new     = (!mode_spi && urx_done) || spi_done;
  assign rx_val     = mode_spi ? spi_word : DATA_W'(urx_data);

  sd_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .sel_ext(clk_ext), .div(div_q),
    .ext_in(ext_tick), .tick(tick));

  sd_uart_tx #(.CHAR_W(CHAR_W), .OVS(OVS)) u_utx (
    .clk(clk), .rst(rst), .tick(tick), .start(uart_start),
    .data(tx_hold[CHAR_W-1:0]), .busy(utx_busy), .txd(txd));

  sd_uart_rx #(.CHAR_W(CHAR_W), .OVS(OVS)) u_urx (
    .clk(clk), .rst(rst), .en(!mode_spi), .tick(tick), .rxd(rxd),
    .done(urx_done), .ferr(urx_ferr), .data(urx_data));

  sd_spi_master #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_spi (
    .clk(clk), .rst(rst), .tick(tick), .start(spi_start), .data(tx_hold),
    .lenm1(lenm1), .miso(miso), .busy(spi_busy), .sclk(sclk), .mosi(mosi),
    .done(spi_done), .rword(spi_word));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_spi <= 1'b0; clk_ext <= 1'b0; lenm1 <= '0; div_q <= '0;
      tx_hold <= '0; tx_full <= 1'b0; rx_hold <= '0; rx_full <= 1'b0;
      ovr <= 1'b0; frm <= 1'b0; sdone <= 1'b0; rdata <= '0;
    end else begin
      if (uart_start || spi_start) tx_full <= 1'b0;
      if (wr_data && !tx_full) begin
        tx_hold <= wdata;
        tx_full <= 1'b1;
      end
      if (wr_en && addr == A_CTRL) begin
        mode_spi <= wdata[0];
        clk_ext  <= wdata[1];
        lenm1    <= wdata[4 +: LEN_W];
      end
      if (wr_en && addr == A_DIV) div_q <= wdata[DIV_W-1:0];
      if (wr_stat) begin
        if (wdata[F_OVR])   ovr   <= 1'b0;
        if (wdata[F_FRAME]) frm   <= 1'b0;
        if (wdata[F_SDONE]) sdone <= 1'b0;
      end
      if (rd_data) rx_full <= 1'b0;
      if (rx_new) begin
        if (rx_full) ovr <= 1'b1;
        else begin
          rx_hold <= rx_val;
          rx_full <= 1'b1;
        end
      end
      if (!mode_spi && urx_ferr) frm <= 1'b1;
      if (spi_done) sdone <= 1'b1;
      if (rd_en) begin
        case (addr)
          A_CTRL:  rdata <= DATA_W'({lenm1, 2'b00, clk_ext, mode_spi});
          A_DATA:  rdata <= rx_hold;
          A_STAT:  rdata <= DATA_W'(flags);
          default: rdata <= DATA_W'(div_q);
        endcase
      end
    end
  end

  always_comb begin
    flags           = '0;
    flags[F_RXFULL] = rx_full;
    flags[F_TXEMPT] = !tx_full;
    flags[F_OVR]    = ovr;
    flags[F_FRAME]  = frm;
    flags[F_SDONE]  = sdone;
  end

  // R3: a data write into a full holding register changes nothing
  a_r3_hold_kept: assert property (@(posedge clk) disable iff (rst)
    (wr_data && tx_full) |=> $stable(tx_hold));
  // R5: a word arriving on a full receive register raises overrun and is dropped
  a_r5_overrun_drop: assert property (@(posedge clk) disable iff (rst)
    (rx_new && rx_full) |=> (ovr && $stable(rx_hold)));
  // R6: a bad stop bit never loads the receive register
  a_r6_frame_drop: assert property (@(posedge clk) disable iff (rst)
    (!mode_spi && urx_ferr) |=> $stable(rx_hold));
endmodule

// File: tb/serial_duo_test.sv
`timescale 1ns/1ps
module serial_duo_test;
  logic        clk = 0, rst = 1;
  logic        wr_en = 0, rd_en = 0;
  logic [1:0]  addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic [4:0]  flags;
  logic        ext_tick = 0, rxd = 1, txd, sclk, mosi, miso = 0;

  int total = 0, bad = 0;
  int bitclk = 32;
  logic [7:0]  txq[$];
  logic [15:0] cap, sw, rv;
  int          sidx = 0;
  logic        pm = 0, ps = 0;

  serial_duo uut (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .flags(flags),
    .ext_tick(ext_tick), .rxd(rxd), .txd(txd), .sclk(sclk), .mosi(mosi),
    .miso(miso));

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic stopv);
    rxd = 0; idle(bitclk);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; idle(bitclk); end
    rxd = stopv; idle(bitclk);
    rxd = 1; idle(bitclk);
  endtask

  task automatic spi_go(input int len, input logic [15:0] tx, input logic [15:0] slave);
    sw = slave; sidx = len - 1; miso = slave[len-1]; cap = 0;
    wr(2'd1, tx);
  endtask

  task automatic wait_done;
    for (int i = 0; i < 3000 && !flags[4]; i++) @(negedge clk);
    idle(2);
  endtask

  // behavioural UART line monitor
  initial forever begin
    logic [7:0] b;
    @(negedge txd);
    idle(bitclk / 2);
    if (txd == 0) begin
      for (int i = 0; i < 8; i++) begin idle(bitclk); b[i] = txd; end
      idle(bitclk);
      chk("R2 stop bit high", txd, 1);
      txq.push_back(b);
    end
  end

  // SPI slave model
  always @(posedge sclk) cap = {cap[14:0], mosi};
  always @(negedge sclk) if (sidx > 0) begin sidx--; miso = sw[sidx]; end

  // per-clock protocol comparison
  always @(negedge clk) begin
    if (!rst && ps && sclk) chk("R7 mosi held while sclk high", mosi, pm);
    pm = mosi; ps = sclk;
  end

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3); rst = 0; idle(2);
    chk("R1 txd", txd, 1);
    chk("R1 sclk", sclk, 0);
    chk("R1 flags", flags, 5'b00010);

    // UART transmit, divider 1 -> bit = 32 clocks
    wr(2'd3, 16'd1); wr(2'd0, 16'h0000);
    wr(2'd1, 16'h00A5); idle(2);
    chk("R3 holding freed after load", flags[1], 1);
    wr(2'd1, 16'h003C); idle(1);
    chk("R3 second word waits", flags[1], 0);
    wr(2'd1, 16'h00FF);
    idle(1100);
    chk("R3 ignored write not sent", txq.size(), 2);
    chk("R2 first char", (txq.size() > 0) ? txq[0] : 0, 8'hA5);
    chk("R2 second char", (txq.size() > 1) ? txq[1] : 0, 8'h3C);
    chk("R3 empty at end", flags[1], 1);

    // UART receive
    send(8'h5A, 1);
    chk("R4 rx full", flags[0], 1);
    rd(2'd1, rv);
    chk("R4 data", rv, 16'h005A);
    chk("R4 read clears full", flags[0], 0);

    // overrun
    send(8'h11, 1); send(8'h22, 1);
    chk("R5 overrun set", flags[2], 1);
    rd(2'd1, rv);
    chk("R5 first kept", rv, 16'h0011);
    wr(2'd2, 16'h0000);
    chk("R10 zero write keeps flag", flags[2], 1);
    wr(2'd2, 16'h001C);
    chk("R10 overrun cleared", flags[2], 0);

    // framing error, then a clean frame
    send(8'h33, 0);
    chk("R6 framing set", flags[3], 1);
    chk("R6 not stored", flags[0], 0);
    send(8'h6C, 1);
    rd(2'd1, rv);
    chk("R6 next frame clean", rv, 16'h006C);
    chk("R6 no phantom overrun", flags[2], 0);
    wr(2'd2, 16'h0008);
    chk("R10 framing cleared", flags[3], 0);

    // SPI, 8 bits, divider 0
    wr(2'd3, 16'd0); wr(2'd0, 16'h0071);
    spi_go(8, 16'h00C3, 16'h0096); wait_done;
    chk("R7 mosi msb first", cap, 16'h00C3);
    chk("R8 spi done", flags[4], 1);
    rd(2'd1, rv);
    chk("R8 received word", rv, 16'h0096);
    chk("R7 sclk idle low", sclk, 0);
    wr(2'd2, 16'h0010);

    // length 1
    wr(2'd0, 16'h0001);
    spi_go(1, 16'h0001, 16'h0001); wait_done;
    chk("R7 len1 out", cap, 16'h0001);
    rd(2'd1, rv);
    chk("R7 len1 in", rv, 16'h0001);
    wr(2'd2, 16'h0010);

    // length 16
    wr(2'd0, 16'h00F1);
    spi_go(16, 16'hBEEF, 16'h1234); wait_done;
    chk("R7 len16 out", cap, 16'hBEEF);
    rd(2'd1, rv);
    chk("R7 len16 in", rv, 16'h1234);
    wr(2'd2, 16'h0010);

    // length 4 with upper bits set: only low 4 go out, input masked
    wr(2'd0, 16'h0031);
    spi_go(4, 16'hFFF0, 16'hFFFA); wait_done;
    chk("R7 len4 out", cap, 16'h0000);
    rd(2'd1, rv);
    chk("R7 len4 masked in", rv, 16'h000A);
    wr(2'd2, 16'h0010);

    // SPI overrun: two words without reading
    spi_go(4, 16'h0003, 16'h0005); wait_done;
    wr(2'd2, 16'h0010);
    spi_go(4, 16'h0004, 16'h0006); wait_done;
    chk("R8 spi overrun", flags[2], 1);
    rd(2'd1, rv);
    chk("R8 first spi word kept", rv, 16'h0005);
    wr(2'd2, 16'h0014);

    // external tick: 4-bit word needs 8 edges
    wr(2'd0, 16'h0033);
    spi_go(4, 16'h0005, 16'h0009);
    idle(60);
    chk("R9 no edge no sclk", sclk, 0);
    chk("R9 no edge not done", flags[4], 0);
    for (int i = 0; i < 7; i++) begin ext_tick = 1; idle(4); ext_tick = 0; idle(4); end
    chk("R9 seven edges not done", flags[4], 0);
    ext_tick = 1; idle(4); ext_tick = 0; idle(4);
    chk("R9 eighth edge done", flags[4], 1);
    chk("R9 ext word out", cap, 16'h0005);
    rd(2'd1, rv);
    chk("R9 ext word in", rv, 16'h0009);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule